// File: doc/BRIEF.md
# I2C 10-Bit Slave Address Matcher

This block decides whether a two-byte (10-bit) slave address sent on an I2C bus selects this device. A byte shifter, which is not part of the block, hands it each completed byte together with one-cycle pulses for Start, Restart and Stop. The block compares the first byte after a Start or Restart against the 10-bit header pattern and the device's two upper address bits. It then compares the second byte against the lower eight bits. For each address byte it returns an ACK or NACK decision, and it reports whether the device is addressed and in which direction.

A full write-direction match leaves a sticky "previously matched" flag set. While that flag is set, the bus master can send a Restart followed by only the header byte with R/W set, and the device is selected for reading. On that read selection the block raises a clock-hold request, which asks the bus side to keep SCL low, and gives a one-cycle transmit-ready pulse. The hold stays up until the data path pulses a release input to say the transmit byte is loaded.

Top module: `tenbit_addr_match`

## Requirements
- R1: After reset, every output (`ack_vld`, `ack`, `addr_match`, `read_mode`, `prior_hit`, `hold_req`, `tx_ready`) is 0.
- R2: The header byte is bits [7:3] = 5'b11110, bits [2:1] = own address bits 9:8, and bit [0] = R/W (1 = read). In the cycle after a matching header with R/W = 0 arrives as the first byte after Start or Restart, `ack_vld` = 1 and `ack` = 1. A first byte with a different prefix or different upper bits gives `ack_vld` = 1 and `ack` = 0.
- R3: After a NACKed address byte, later bytes produce no `ack_vld` until the next Start or Restart.
- R4: The byte after an ACKed write header is compared with own address bits 7:0. On a match it is ACKed and `addr_match` = 1 with `read_mode` = 0. On a mismatch it is NACKed and `addr_match` stays 0.
- R5: A full header-plus-low-byte write match sets `prior_hit` in the same cycle that `addr_match` rises.
- R6: A Stop clears `prior_hit`.
- R7: A header byte with R/W = 0 clears `prior_hit`, whether or not it matches. A header byte that fails to match also clears `prior_hit`.
- R8: A Start or a Restart re-arms the matcher, so the next byte is treated as a header byte, whatever state the matcher was in.
- R9: When `prior_hit` is 1 and a matching header with R/W = 1 arrives after a Restart, the next cycle shows `ack` = 1, `addr_match` = 1 and `read_mode` = 1, `hold_req` = 1, and `tx_ready` = 1 for exactly one cycle.
- R10: A matching header with R/W = 1 while `prior_hit` = 0 is NACKed and `read_mode` stays 0.
- R11: `hold_req` stays 1 until a `release_hold` pulse, a Stop, a Start or a Restart, and it falls in the cycle after that event.
- R12: A Stop leaves the matcher unaddressed (`addr_match` = `read_mode` = 0), with bytes ignored. In the same cycle, Stop has priority over Start or Restart, and any event has priority over `byte_vld`, so that byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 10 | Static 10-bit slave address |
| byte_vld | input | 1 | One-cycle strobe: a received byte is complete |
| byte_data | input | 8 | Received byte |
| start_evt | input | 1 | Start condition pulse |
| restart_evt | input | 1 | Repeated-start condition pulse |
| stop_evt | input | 1 | Stop condition pulse |
| release_hold | input | 1 | Pulse: transmit data loaded, drop clock hold |
| ack_vld | output | 1 | One-cycle strobe: ACK decision for an address byte |
| ack | output | 1 | 1 = ACK, 0 = NACK (valid with `ack_vld`) |
| addr_match | output | 1 | Device is addressed |
| read_mode | output | 1 | Device is addressed for reading |
| prior_hit | output | 1 | Sticky full write-match flag |
| hold_req | output | 1 | Request to keep SCL low |
| tx_ready | output | 1 | One-cycle pulse on read selection |

## Verification
Every result sits one register stage behind its cause. An ACK decision, a mode change, the flag update and the hold or ready outputs all appear right after the clock edge that samples the byte strobe or event pulse. The bench drives each stimulus on a falling edge and holds it for exactly one cycle. It reads the outputs on the next falling edge, halfway through the cycle in which they are first valid. Checks that one-cycle strobes have ended are made one further falling edge later.

// File: rtl/tenbit_addr_match.sv
module tenbit_addr_match #(
  parameter logic [4:0] HDR_PREFIX = 5'b11110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] own_addr,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       start_evt,
  input  logic       restart_evt,
  input  logic       stop_evt,
  input  logic       release_hold,
  output logic       ack_vld,
  output logic       ack,
  output logic       addr_match,
  output logic       read_mode,
  output logic       prior_hit,
  output logic       hold_req,
  output logic       tx_ready
);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_LOW, S_WRITE, S_READ} st_t;
  st_t st;

  logic hdr_ok, low_ok, rw_bit;
  assign hdr_ok = (byte_data[7:3] == HDR_PREFIX) && (byte_data[2:1] == own_addr[9:8]);
  assign low_ok = (byte_data == own_addr[7:0]);
  assign rw_bit = byte_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ack_vld   <= 1'b0;
      ack       <= 1'b0;
      prior_hit <= 1'b0;
      hold_req  <= 1'b0;
      tx_ready  <= 1'b0;
    end else begin
      ack_vld  <= 1'b0;
      ack      <= 1'b0;
      tx_ready <= 1'b0;
      if (stop_evt) begin
        st        <= S_IDLE;
        prior_hit <= 1'b0;
        hold_req  <= 1'b0;
      end else if (start_evt || restart_evt) begin
        st       <= S_HDR;
        hold_req <= 1'b0;
      end else begin
        if (release_hold) hold_req <= 1'b0;
        if (byte_vld) begin
          case (st)
            S_HDR: begin
              ack_vld <= 1'b1;
              if (!hdr_ok) begin
                prior_hit <= 1'b0;
                st        <= S_IDLE;
              end else if (!rw_bit) begin
                ack       <= 1'b1;
                prior_hit <= 1'b0;
                st        <= S_LOW;
              end else if (prior_hit) begin
                ack      <= 1'b1;
                hold_req <= 1'b1;
                tx_ready <= 1'b1;
                st       <= S_READ;
              end else begin
                st <= S_IDLE;
              end
            end
            S_LOW: begin
              ack_vld <= 1'b1;
              if (low_ok) begin
                ack       <= 1'b1;
                prior_hit <= 1'b1;
                st        <= S_WRITE;
              end else begin
                st <= S_IDLE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign addr_match = (st == S_WRITE) || (st == S_READ);
  assign read_mode  = (st == S_READ);

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!prior_hit && !hold_req && !addr_match)); // R6
  AST_READ_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(read_mode) |-> $past(prior_hit)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && (release_hold || start_evt || restart_evt)) |=> !hold_req); // R11
  AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && !release_hold && !stop_evt && !start_evt && !restart_evt) |=> hold_req); // R11
  AST_PRIOR_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prior_hit) |-> (addr_match && !read_mode)); // R5
  AST_TXRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (hold_req && read_mode)); // R9
  AST_NACK_UNADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !ack) |-> !addr_match); // R3
  AST_EVT_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || restart_evt || stop_evt) |=> !ack_vld); // R12

endmodule

// File: tb/tenbit_addr_match_test.sv
module tenbit_addr_match_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] own_addr = 10'h2A5;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic start_evt = 1'b0, restart_evt = 1'b0, stop_evt = 1'b0, release_hold = 1'b0;
  logic ack_vld, ack, addr_match, read_mode, prior_hit, hold_req, tx_ready;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  localparam logic [7:0] HW = 8'hF4, HR = 8'hF5, LO = 8'hA5;

  always #2.5 clk = ~clk;

  tenbit_addr_match uut (.clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .start_evt(start_evt),
    .restart_evt(restart_evt), .stop_evt(stop_evt), .release_hold(release_hold),
    .ack_vld(ack_vld), .ack(ack), .addr_match(addr_match), .read_mode(read_mode),
    .prior_hit(prior_hit), .hold_req(hold_req), .tx_ready(tx_ready));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic ev(bit s, bit r, bit p, bit rel);
    @(negedge clk); start_evt = s; restart_evt = r; stop_evt = p; release_hold = rel;
    @(negedge clk); start_evt = 0; restart_evt = 0; stop_evt = 0; release_hold = 0;
  endtask

  task automatic full_write();
    ev(1, 0, 0, 0); send(HW); send(LO);
  endtask

  task automatic t_reset();
    chk("R1 ack_vld", ack_vld, 0); chk("R1 addr_match", addr_match, 0);
    chk("R1 read_mode", read_mode, 0); chk("R1 prior_hit", prior_hit, 0);
    chk("R1 hold_req", hold_req, 0); chk("R1 tx_ready", tx_ready, 0);
  endtask

  task automatic t_write_match();
    ev(1, 0, 0, 0);
    send(HW); chk("R2 ack_vld", ack_vld, 1); chk("R2 ack", ack, 1);
    chk("R2 addr_match early", addr_match, 0);
    send(LO); chk("R4 ack", ack, 1); chk("R4 addr_match", addr_match, 1);
    chk("R4 read_mode", read_mode, 0); chk("R5 prior_hit", prior_hit, 1);
    send(8'h33); chk("R4 data byte no ack_vld", ack_vld, 0);
  endtask

  task automatic t_read_restart();
    ev(0, 1, 0, 0);
    send(HR); chk("R9 ack", ack, 1); chk("R9 read_mode", read_mode, 1);
    chk("R9 addr_match", addr_match, 1); chk("R9 hold_req", hold_req, 1);
    chk("R9 tx_ready", tx_ready, 1);
    @(negedge clk); chk("R9 tx_ready pulse", tx_ready, 0); chk("R11 hold kept", hold_req, 1);
    ev(0, 0, 0, 1); chk("R11 released", hold_req, 0); chk("R11 read kept", read_mode, 1);
  endtask

  task automatic t_stop_then_read();
    ev(0, 0, 1, 0); chk("R6 prior cleared", prior_hit, 0);
    chk("R12 addr_match", addr_match, 0); chk("R12 read_mode", read_mode, 0);
    send(HW); chk("R12 ignored after stop", ack_vld, 0);
    ev(0, 1, 0, 0); send(HR); chk("R10 ack_vld", ack_vld, 1); chk("R10 nack", ack, 0);
    chk("R10 read_mode", read_mode, 0); chk("R10 hold", hold_req, 0);
  endtask

  task automatic t_hdr_write_clears();
    full_write(); chk("R5 set", prior_hit, 1);
    ev(0, 1, 0, 0); send(HW); chk("R7 ack", ack, 1); chk("R7 rw0 clears", prior_hit, 0);
    ev(0, 1, 0, 0); send(HR); chk("R7 read refused", ack, 0);
  endtask

  task automatic t_hdr_mismatch();
    full_write();
    ev(0, 1, 0, 0); send(8'hF0); chk("R7 mismatch nack", ack, 0);
    chk("R7 mismatch clears", prior_hit, 0);
    send(LO); chk("R3 ignored", ack_vld, 0);
    ev(1, 0, 0, 0); send(HW); chk("R8 rearmed", ack, 1);
    send(8'hA4); chk("R4 low mismatch nack", ack, 0); chk("R4 low mismatch unaddr", addr_match, 0);
    send(LO); chk("R3 ignored after low nack", ack_vld, 0);
  endtask

  task automatic t_prefix();
    ev(1, 0, 0, 0); send(8'h74); chk("R2 wrong prefix vld", ack_vld, 1); chk("R2 wrong prefix nack", ack, 0);
    ev(1, 0, 0, 0); send(8'hF6); chk("R2 wrong upper bits", ack, 0);
  endtask

  task automatic t_priority();
    full_write();
    ev(1, 0, 1, 0); chk("R12 stop wins addr", addr_match, 0); chk("R12 stop wins prior", prior_hit, 0);
    send(HW); chk("R12 stop wins over start", ack_vld, 0);
    @(negedge clk); start_evt = 1; byte_vld = 1; byte_data = HW;
    @(negedge clk); start_evt = 0; byte_vld = 0;
    chk("R12 byte dropped with event", ack_vld, 0);
    send(HW); chk("R8 header after start", ack, 1);
  endtask

  task automatic t_hold_by_restart();
    full_write(); ev(0, 1, 0, 0); send(HR); chk("R9 hold set", hold_req, 1);
    ev(0, 1, 0, 0); chk("R11 restart drops hold", hold_req, 0);
    send(HR); chk("R8 reselect read", read_mode, 1);
    ev(0, 0, 1, 0); chk("R11 stop drops hold", hold_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_match();
    t_read_restart();
    t_stop_then_read();
    t_hdr_write_clears();
    t_hdr_mismatch();
    t_prefix();
    t_priority();
    t_hold_by_restart();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule